// File: doc/BRIEF.md
# Accumulator ALU with Registered Status Flags

This block is the arithmetic and logic datapath of a small accumulator-style processor. Each cycle it takes an operation code, a register operand A, a memory operand M and the present carry flag. It computes a data result together with new values for the carry, zero, negative and overflow flags. It also produces values for the interrupt-mask and decimal flags when an operation targets them. Every flag comes with an update enable. The surrounding status register loads a flag only while its enable is high and otherwise keeps its old value. All outputs are registered, so a result appears on the clock edge after its operands are presented.

The datapath has one adder. Subtraction feeds it the complement of M with the carry acting as not-borrow. Compare forces the carry-in high. Increment and decrement feed it a constant. Compare and bit test change flags only and produce no storable result. A separate group of flag-only operations sets or clears a single status bit. Decimal arithmetic is not performed, and the decimal flag has no effect on the add or subtract path. The data width is a parameter (default 8). Another parameter selects whether the adder is written as an explicit ripple chain or as a behavioural sum.

Top module: `flag_alu`

## Requirements
- R1: Operation code 0 (add) yields R = A + M + C modulo 256 with the result strobe set. C is set when the 9-bit sum exceeds 0xFF. C, Z, N and V are enabled.
- R2: For add and subtract, V is set exactly when bit 7 of (B xor R) and (R xor A) is 1. B is the adder's second operand: M for add, the complement of M for subtract.
- R3: Operation code 1 (subtract) yields R = A + ~M + C modulo 256. C is the carry out of that sum (1 means no borrow). C, Z, N and V are enabled.
- R4: Whenever the result strobe is set, Z is 1 exactly when R is 0 and N equals R bit 7. Operation codes 2 (AND), 3 (XOR) and 4 (OR) enable only Z and N.
- R5: Operation code 5 shifts A left, moving bit 7 into C and 0 into bit 0. Operation code 6 shifts A right, moving bit 0 into C and 0 into bit 7. Both enable C, Z and N.
- R6: Operation code 7 rotates A left, moving the old C into bit 0 and bit 7 into the new C. Operation code 8 rotates A right, moving the old C into bit 7 and bit 0 into the new C. Both enable C, Z and N.
- R7: Operation code 11 (compare) clears the result strobe. It sets C when A >= M (unsigned) and takes Z and N from the 8-bit value A - M. Only C, Z and N are enabled.
- R8: Operation code 12 (bit test) clears the result strobe. Z is 1 when (A and M) is zero, N takes M bit 7 and V takes M bit 6. Only Z, N and V are enabled.
- R9: Operation codes 9 (increment) and 10 (decrement) produce A + 1 and A - 1 modulo 256 and enable only Z and N.
- R10: A flag that an operation does not affect has its enable low. Operation codes 20 to 31 assert no enable and no result strobe.
- R11: Each flag-only code clears the result strobe and enables exactly one flag with the given value: 13 sets C, 14 clears C, 15 sets I, 16 clears I, 17 sets D, 18 clears D, 19 clears V.
- R12: Outputs are registered with one cycle of latency. While reset (active low) is asserted, the result, all flag values, the result strobe and all enables are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 5 | Operation code |
| a_i | input | DATA_W | Register operand A |
| m_i | input | DATA_W | Memory operand M |
| c_i | input | 1 | Present carry flag |
| res_o | output | DATA_W | Registered result |
| res_we_o | output | 1 | Result is valid for storage |
| c_o | output | 1 | New carry value |
| z_o | output | 1 | New zero value |
| n_o | output | 1 | New negative value |
| v_o | output | 1 | New overflow value |
| i_o | output | 1 | New interrupt-mask value |
| d_o | output | 1 | New decimal value |
| c_en_o | output | 1 | Carry update enable |
| z_en_o | output | 1 | Zero update enable |
| n_en_o | output | 1 | Negative update enable |
| v_en_o | output | 1 | Overflow update enable |
| i_en_o | output | 1 | Interrupt-mask update enable |
| d_en_o | output | 1 | Decimal update enable |

## Verification
The bench builds two copies of the block at DATA_W = 8, one with the behavioural adder and one with the explicit ripple chain. Both copies are checked against the same expected values, so a carry-chain error in either variant shows up against the other. At eight bits, random operands reach every carry, borrow and sign-overflow combination within a few thousand vectors. Directed vectors cover the exact edges: the 0xFF + 1 wrap, signed overflow in both directions, compare with equal operands, and rotates that carry a set flag in and out.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   localparam int OP_W = 5;

   typedef enum logic [OP_W-1:0] {
      OP_ADD  = 5'd0,
      OP_SUB  = 5'd1,
      OP_AND  = 5'd2,
      OP_XOR  = 5'd3,
      OP_OR   = 5'd4,
      OP_SHL  = 5'd5,
      OP_SHR  = 5'd6,
      OP_ROL  = 5'd7,
      OP_ROR  = 5'd8,
      OP_INC  = 5'd9,
      OP_DEC  = 5'd10,
      OP_CMP  = 5'd11,
      OP_BIT  = 5'd12,
      OP_SETC = 5'd13,
      OP_CLRC = 5'd14,
      OP_SETI = 5'd15,
      OP_CLRI = 5'd16,
      OP_SETD = 5'd17,
      OP_CLRD = 5'd18,
      OP_CLRV = 5'd19
   } alu_op_e;

   typedef enum logic [1:0] {
      SRC_ADD   = 2'd0,
      SRC_LOGIC = 2'd1,
      SRC_SHIFT = 2'd2,
      SRC_NONE  = 2'd3
   } res_src_e;

   typedef enum logic [1:0] {
      LG_AND = 2'd0,
      LG_XOR = 2'd1,
      LG_OR  = 2'd2
   } logic_sel_e;

   typedef enum logic [1:0] {
      SH_LEFT  = 2'd0,
      SH_RIGHT = 2'd1,
      SH_ROL   = 2'd2,
      SH_ROR   = 2'd3
   } shift_sel_e;

   typedef struct packed {
      logic c;
      logic z;
      logic n;
      logic v;
      logic i;
      logic d;
   } flag_vec_t;

endpackage

// File: rtl/alu_add.sv
module alu_add #(
   parameter int DATA_W     = 8,
   parameter bit RIPPLE_ADD = 1'b0
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              ci_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              co_o
);

   generate
      if (RIPPLE_ADD) begin : g_ripple
         logic [DATA_W:0] cy;
         assign cy[0] = ci_i;
         for (genvar k = 0; k < DATA_W; k++) begin : g_cell
            assign sum_o[k] = a_i[k] ^ b_i[k] ^ cy[k];
            assign cy[k+1]  = (a_i[k] & b_i[k]) | (cy[k] & (a_i[k] ^ b_i[k]));
         end
         assign co_o = cy[DATA_W];
      end else begin : g_behav
         logic [DATA_W:0] wide;
         assign wide  = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, ci_i};
         assign sum_o = wide[DATA_W-1:0];
         assign co_o  = wide[DATA_W];
      end
   endgenerate

endmodule

// File: rtl/alu_logic.sv
module alu_logic
   import alu8_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic_sel_e        sel_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] m_i,
   output logic [DATA_W-1:0] res_o
);

   always_comb begin
      unique case (sel_i)
         LG_AND:  res_o = a_i & m_i;
         LG_XOR:  res_o = a_i ^ m_i;
         LG_OR:   res_o = a_i | m_i;
         default: res_o = '0;
      endcase
   end

endmodule

// File: rtl/alu_shift.sv
module alu_shift
   import alu8_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  shift_sel_e        sel_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic              ci_i,
   output logic [DATA_W-1:0] res_o,
   output logic              co_o
);

   localparam int MSB = DATA_W - 1;

   logic fill_lo;
   logic fill_hi;

   // Rotates feed the incoming carry into the vacated end; plain shifts feed 0.
   assign fill_lo = (sel_i == SH_ROL) ? ci_i : 1'b0;
   assign fill_hi = (sel_i == SH_ROR) ? ci_i : 1'b0;

   always_comb begin
      unique case (sel_i)
         SH_LEFT, SH_ROL: begin
            res_o = {a_i[MSB-1:0], fill_lo};
            co_o  = a_i[MSB];
         end
         default: begin
            res_o = {fill_hi, a_i[MSB:1]};
            co_o  = a_i[0];
         end
      endcase
   end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
   import alu8_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter bit RIPPLE_ADD = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [4:0]        op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] m_i,
   input  logic              c_i,
   output logic [DATA_W-1:0] res_o,
   output logic              res_we_o,
   output logic              c_o,
   output logic              z_o,
   output logic              n_o,
   output logic              v_o,
   output logic              i_o,
   output logic              d_o,
   output logic              c_en_o,
   output logic              z_en_o,
   output logic              n_en_o,
   output logic              v_en_o,
   output logic              i_en_o,
   output logic              d_en_o
);

   localparam int MSB = DATA_W - 1;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("flag_alu: DATA_W must be at least 2");
      end
   endgenerate

   alu_op_e     op;
   assign op = alu_op_e'(op_i);

   // ---------------- control decode ----------------
   logic [DATA_W-1:0] add_b;
   logic              add_ci;
   res_src_e          src;
   logic_sel_e        lg_sel;
   shift_sel_e        sh_sel;
   logic              we_d;
   flag_vec_t         en_d;
   flag_vec_t         val_d;

   // ---------------- datapath ----------------
   logic [DATA_W-1:0] add_sum;
   logic              add_co;
   logic [DATA_W-1:0] lg_res;
   logic [DATA_W-1:0] sh_res;
   logic              sh_co;
   logic [DATA_W-1:0] res_mux;
   logic              add_ovf;

   alu_add #(.DATA_W(DATA_W), .RIPPLE_ADD(RIPPLE_ADD)) u_add (
      .a_i   (a_i),
      .b_i   (add_b),
      .ci_i  (add_ci),
      .sum_o (add_sum),
      .co_o  (add_co)
   );

   alu_logic #(.DATA_W(DATA_W)) u_logic (
      .sel_i (lg_sel),
      .a_i   (a_i),
      .m_i   (m_i),
      .res_o (lg_res)
   );

   alu_shift #(.DATA_W(DATA_W)) u_shift (
      .sel_i (sh_sel),
      .a_i   (a_i),
      .ci_i  (c_i),
      .res_o (sh_res),
      .co_o  (sh_co)
   );

   // Sign overflow: both the second addend and A disagree in sign with the sum.
   assign add_ovf = (add_b[MSB] ^ add_sum[MSB]) & (add_sum[MSB] ^ a_i[MSB]);

   always_comb begin
      unique case (src)
         SRC_ADD:   res_mux = add_sum;
         SRC_LOGIC: res_mux = lg_res;
         SRC_SHIFT: res_mux = sh_res;
         default:   res_mux = '0;
      endcase
   end

   always_comb begin
      add_b   = m_i;
      add_ci  = c_i;
      src     = SRC_ADD;
      lg_sel  = LG_AND;
      sh_sel  = SH_LEFT;
      we_d    = 1'b0;
      en_d    = '0;
      val_d   = '0;

      unique case (op)
         OP_ADD: begin
            we_d = 1'b1;
            en_d.c = 1'b1; en_d.z = 1'b1; en_d.n = 1'b1; en_d.v = 1'b1;
         end
         OP_SUB: begin
            add_b = ~m_i;
            we_d  = 1'b1;
            en_d.c = 1'b1; en_d.z = 1'b1; en_d.n = 1'b1; en_d.v = 1'b1;
         end
         OP_CMP: begin
            add_b  = ~m_i;
            add_ci = 1'b1;
            en_d.c = 1'b1; en_d.z = 1'b1; en_d.n = 1'b1;
         end
         OP_INC: begin
            add_b  = '0;
            add_ci = 1'b1;
            we_d   = 1'b1;
            en_d.z = 1'b1; en_d.n = 1'b1;
         end
         OP_DEC: begin
            add_b  = '1;
            add_ci = 1'b0;
            we_d   = 1'b1;
            en_d.z = 1'b1; en_d.n = 1'b1;
         end
         OP_AND, OP_XOR, OP_OR: begin
            src    = SRC_LOGIC;
            lg_sel = (op == OP_AND) ? LG_AND : (op == OP_XOR) ? LG_XOR : LG_OR;
            we_d   = 1'b1;
            en_d.z = 1'b1; en_d.n = 1'b1;
         end
         OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
            src    = SRC_SHIFT;
            sh_sel = (op == OP_SHL) ? SH_LEFT  :
                     (op == OP_SHR) ? SH_RIGHT :
                     (op == OP_ROL) ? SH_ROL   : SH_ROR;
            we_d   = 1'b1;
            en_d.c = 1'b1; en_d.z = 1'b1; en_d.n = 1'b1;
         end
         OP_BIT: begin
            src    = SRC_LOGIC;
            lg_sel = LG_AND;
            en_d.z = 1'b1; en_d.n = 1'b1; en_d.v = 1'b1;
         end
         OP_SETC: begin en_d.c = 1'b1; val_d.c = 1'b1; src = SRC_NONE; end
         OP_CLRC: begin en_d.c = 1'b1; val_d.c = 1'b0; src = SRC_NONE; end
         OP_SETI: begin en_d.i = 1'b1; val_d.i = 1'b1; src = SRC_NONE; end
         OP_CLRI: begin en_d.i = 1'b1; val_d.i = 1'b0; src = SRC_NONE; end
         OP_SETD: begin en_d.d = 1'b1; val_d.d = 1'b1; src = SRC_NONE; end
         OP_CLRD: begin en_d.d = 1'b1; val_d.d = 1'b0; src = SRC_NONE; end
         OP_CLRV: begin en_d.v = 1'b1; val_d.v = 1'b0; src = SRC_NONE; end
         default: src = SRC_NONE;
      endcase

      // Value selection for the arithmetic flags, shared by all result paths.
      if (en_d.c && src == SRC_SHIFT) val_d.c = sh_co;
      else if (en_d.c && src == SRC_ADD) val_d.c = add_co;
      if (en_d.z) val_d.z = (res_mux == '0);
      if (en_d.n) val_d.n = (op == OP_BIT) ? m_i[MSB] : res_mux[MSB];
      if (en_d.v && op == OP_BIT) val_d.v = m_i[MSB-1];
      else if (en_d.v && src == SRC_ADD) val_d.v = add_ovf;
   end

   // ---------------- registered output stage ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_o    <= '0;
         res_we_o <= 1'b0;
         c_o <= 1'b0; z_o <= 1'b0; n_o <= 1'b0;
         v_o <= 1'b0; i_o <= 1'b0; d_o <= 1'b0;
         c_en_o <= 1'b0; z_en_o <= 1'b0; n_en_o <= 1'b0;
         v_en_o <= 1'b0; i_en_o <= 1'b0; d_en_o <= 1'b0;
      end else begin
         res_o    <= we_d ? res_mux : '0;
         res_we_o <= we_d;
         c_o <= val_d.c; z_o <= val_d.z; n_o <= val_d.n;
         v_o <= val_d.v; i_o <= val_d.i; d_o <= val_d.d;
         c_en_o <= en_d.c; z_en_o <= en_d.z; n_en_o <= en_d.n;
         v_en_o <= en_d.v; i_en_o <= en_d.i; d_en_o <= en_d.d;
      end
   end

   // ---------------- assertions ----------------
   AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 5'd0) |=> (c_o == (({1'b0, $past(a_i)} + {1'b0, $past(m_i)} + {{DATA_W{1'b0}}, $past(c_i)}) > {1'b0, {DATA_W{1'b1}}}))); // R1

   AST_ZERO_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      res_we_o |-> (z_en_o && n_en_o && (z_o == (res_o == '0)) && (n_o == res_o[MSB]))); // R4

   AST_CMP_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 5'd11) |=> (!res_we_o && (c_o == ($past(a_i) >= $past(m_i))))); // R7

   AST_BIT_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 5'd12) |=> (!res_we_o && !c_en_o && v_o == $past(m_i[MSB-1]))); // R8

   AST_INCDEC_KEEP_CV: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 5'd9 || op_i == 5'd10) |=> (!c_en_o && !v_en_o)); // R9

   AST_LOGIC_KEEP_CV: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i >= 5'd2 && op_i <= 5'd4) |=> (!c_en_o && !v_en_o)); // R4

   AST_UNDEF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i >= 5'd20) |=> ($countones({c_en_o, z_en_o, n_en_o, v_en_o, i_en_o, d_en_o, res_we_o}) == 0)); // R10

   AST_FLAG_OP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i >= 5'd13 && op_i <= 5'd19) |=> (!res_we_o && $onehot0({c_en_o, z_en_o, n_en_o, v_en_o, i_en_o, d_en_o})
                                           && $countones({c_en_o, i_en_o, d_en_o, v_en_o}) == 1)); // R11

endmodule

// File: tb/test_flag_alu.sv
module test_flag_alu;

   logic       clk;
   logic       rst_n;
   logic [4:0] op;
   logic [7:0] a;
   logic [7:0] m;
   logic       cin;

   logic [7:0] res0, res1;
   logic       we0, c0, z0, n0, v0, i0, d0, ce0, ze0, ne0, ve0, ie0, de0;
   logic       we1, c1, z1, n1, v1, i1, d1, ce1, ze1, ne1, ve1, ie1, de1;

   int vec_cnt;
   int fail_cnt;
   bit finished;

   initial clk = 1'b0;
   always #10 clk = ~clk;

   flag_alu #(.DATA_W(8), .RIPPLE_ADD(1'b0)) i_flag_alu (
      .clk(clk), .rst_n(rst_n), .op_i(op), .a_i(a), .m_i(m), .c_i(cin),
      .res_o(res0), .res_we_o(we0), .c_o(c0), .z_o(z0), .n_o(n0), .v_o(v0),
      .i_o(i0), .d_o(d0), .c_en_o(ce0), .z_en_o(ze0), .n_en_o(ne0),
      .v_en_o(ve0), .i_en_o(ie0), .d_en_o(de0)
   );

   flag_alu #(.DATA_W(8), .RIPPLE_ADD(1'b1)) i_flag_alu_rip (
      .clk(clk), .rst_n(rst_n), .op_i(op), .a_i(a), .m_i(m), .c_i(cin),
      .res_o(res1), .res_we_o(we1), .c_o(c1), .z_o(z1), .n_o(n1), .v_o(v1),
      .i_o(i1), .d_o(d1), .c_en_o(ce1), .z_en_o(ze1), .n_en_o(ne1),
      .v_en_o(ve1), .i_en_o(ie1), .d_en_o(de1)
   );

   // expected: {res[7:0], we, c,z,n,v,i,d, ce,ze,ne,ve,ie,de}
   function automatic logic [20:0] model(input logic [4:0] o, input logic [7:0] x,
                                         input logic [7:0] y, input logic ci);
      logic [7:0] r, b;
      logic we, fc, fz, fn, fv, fi, fd;
      logic [5:0] en;
      int sum;
      r = 8'h00; we = 1'b0; en = 6'b0;
      fc = 0; fz = 0; fn = 0; fv = 0; fi = 0; fd = 0;
      case (o)
         5'd0, 5'd1: begin                         // R1 R3 R2
            b   = (o == 5'd0) ? y : ~y;
            sum = int'(x) + int'(b) + int'(ci);
            r   = sum[7:0];
            fc  = (sum > 255);
            fv  = ((b ^ r) & (r ^ x)) >> 7 != 0;
            we  = 1; en = 6'b111100;
         end
         5'd2: begin r = x & y; we = 1; en = 6'b011000; end   // R4
         5'd3: begin r = x ^ y; we = 1; en = 6'b011000; end
         5'd4: begin r = x | y; we = 1; en = 6'b011000; end
         5'd5: begin r = x << 1; fc = x[7]; we = 1; en = 6'b111000; end            // R5
         5'd6: begin r = x >> 1; fc = x[0]; we = 1; en = 6'b111000; end
         5'd7: begin r = {x[6:0], ci}; fc = x[7]; we = 1; en = 6'b111000; end      // R6
         5'd8: begin r = {ci, x[7:1]}; fc = x[0]; we = 1; en = 6'b111000; end
         5'd9:  begin r = x + 8'd1; we = 1; en = 6'b011000; end                    // R9
         5'd10: begin r = x - 8'd1; we = 1; en = 6'b011000; end
         5'd11: begin                                                               // R7
            b  = x - y;
            fc = (x >= y); fz = (b == 0); fn = b[7];
            en = 6'b111000;
         end
         5'd12: begin fz = ((x & y) == 0); fn = y[7]; fv = y[6]; en = 6'b011100; end // R8
         5'd13: begin fc = 1; en = 6'b100000; end                                   // R11
         5'd14: begin fc = 0; en = 6'b100000; end
         5'd15: begin fi = 1; en = 6'b000010; end
         5'd16: begin fi = 0; en = 6'b000010; end
         5'd17: begin fd = 1; en = 6'b000001; end
         5'd18: begin fd = 0; en = 6'b000001; end
         5'd19: begin fv = 0; en = 6'b000100; end
         default: ;                                                                 // R10
      endcase
      if (we) begin fz = (r == 0); fn = r[7]; end
      return {r, we, fc, fz, fn, fv, fi, fd, en};
   endfunction

   function automatic string tag_of(input logic [4:0] o);
      case (o)
         5'd0: return "R1";
         5'd1: return "R3";
         5'd2, 5'd3, 5'd4: return "R4";
         5'd5, 5'd6: return "R5";
         5'd7, 5'd8: return "R6";
         5'd9, 5'd10: return "R9";
         5'd11: return "R7";
         5'd12: return "R8";
         5'd13, 5'd14, 5'd15, 5'd16, 5'd17, 5'd18, 5'd19: return "R11";
         default: return "R10";
      endcase
   endfunction

   function automatic logic [20:0] mask_of(input logic [20:0] e);
      logic [20:0] mk;
      mk = 21'h1FFFFF;
      if (!e[12]) mk[20:13] = 8'h00;          // result only when stored
      for (int k = 0; k < 6; k++)
         if (!e[k]) mk[6 + k] = 1'b0;         // flag value only when enabled
      return mk;
   endfunction

   task automatic compare(input string tag, input string dut, input logic [20:0] got,
                          input logic [20:0] exp);
      logic [20:0] mk;
      mk = mask_of(exp);
      vec_cnt++;
      if ((got & mk) !== (exp & mk)) begin
         fail_cnt++;
         $display("FAIL %s %s op=%0d a=%02h m=%02h c=%0b actual=%06h expected=%06h mask=%06h",
                  tag, dut, op, a, m, cin, got, exp, mk);
      end
   endtask

   task automatic apply(input logic [4:0] o, input logic [7:0] x, input logic [7:0] y,
                        input logic ci, input string tag);
      logic [20:0] e;
      @(negedge clk);
      op = o; a = x; m = y; cin = ci;
      @(negedge clk);                          // one register of latency (R12)
      e = model(o, x, y, ci);
      compare(tag, "beh", {res0, we0, c0, z0, n0, v0, i0, d0, ce0, ze0, ne0, ve0, ie0, de0}, e);
      compare(tag, "rip", {res1, we1, c1, z1, n1, v1, i1, d1, ce1, ze1, ne1, ve1, ie1, de1}, e);
   endtask

   initial begin
      #(20 * 200000);
      if (!finished) begin
         fail_cnt++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, fail_cnt);
         $finish;
      end
   end

   initial begin
      logic [4:0] ro;
      void'($urandom(32'h1234_5678));
      vec_cnt = 0; fail_cnt = 0; finished = 0;
      rst_n = 1'b0; op = 5'd0; a = 8'h5A; m = 8'hA5; cin = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R12: everything cleared in reset, even with live operands
      vec_cnt++;
      if ({res0, we0, c0, z0, n0, v0, i0, d0, ce0, ze0, ne0, ve0, ie0, de0} !== 21'h0) begin
         fail_cnt++;
         $display("FAIL R12 reset state actual=%06h expected=000000",
                  {res0, we0, c0, z0, n0, v0, i0, d0, ce0, ze0, ne0, ve0, ie0, de0});
      end
      rst_n = 1'b1;

      // directed corners
      apply(5'd0, 8'hFF, 8'h00, 1'b1, "R1");   // wraps to 0, carry out, Z
      apply(5'd0, 8'h50, 8'h50, 1'b0, "R2");   // positive overflow to 0xA0
      apply(5'd0, 8'h80, 8'hFF, 1'b0, "R2");   // negative overflow
      apply(5'd1, 8'h50, 8'hB0, 1'b1, "R2");   // subtract overflow
      apply(5'd1, 8'h00, 8'h01, 1'b1, "R3");   // borrow: 0xFF, C=0
      apply(5'd1, 8'h05, 8'h03, 1'b0, "R3");   // carry clear adds extra borrow
      apply(5'd2, 8'hF0, 8'h0F, 1'b1, "R4");   // AND to zero
      apply(5'd4, 8'h80, 8'h01, 1'b0, "R4");
      apply(5'd5, 8'h80, 8'h00, 1'b0, "R5");   // bit 7 out, zero result
      apply(5'd6, 8'h01, 8'h00, 1'b1, "R5");   // 0 shifted in despite C=1
      apply(5'd7, 8'h80, 8'h00, 1'b1, "R6");   // 0x01, C=1
      apply(5'd8, 8'h01, 8'h00, 1'b1, "R6");   // 0x80, C=1
      apply(5'd11, 8'h42, 8'h42, 1'b0, "R7");  // equal: C=1 Z=1
      apply(5'd11, 8'h10, 8'h20, 1'b1, "R7");  // below: C=0 N=1
      apply(5'd12, 8'h0F, 8'hC0, 1'b0, "R8");  // Z=1 N=1 V=1
      apply(5'd9, 8'hFF, 8'h00, 1'b1, "R9");   // wrap to zero
      apply(5'd10, 8'h00, 8'h00, 1'b0, "R9");  // wrap to 0xFF
      apply(5'd25, 8'h12, 8'h34, 1'b1, "R10");
      for (int k = 13; k <= 19; k++)
         apply(5'(k), 8'h00, 8'h00, 1'b0, "R11");

      // constrained random
      for (int k = 0; k < 3000; k++) begin
         ro = ($urandom_range(9) == 0) ? 5'($urandom_range(31, 20)) : 5'($urandom_range(19));
         apply(ro, 8'($urandom), 8'($urandom), 1'($urandom), tag_of(ro));
      end

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, fail_cnt);
      $finish;
   end

endmodule